// File: doc/BRIEF.md
# Kernel Control and Status Register Block

This block is an AXI4-Lite slave register file that sits between host software and a streaming compute kernel. Software sets up four 32-bit coefficients, launches the kernel by setting a start bit, and polls a control word until a done flag appears. When the kernel returns, it presents a halted flag, an error code and the ID of the offending transaction, and the block keeps those values for software to read. Error code 0 means no error.

On the core side the block gives a one-cycle start pulse and the coefficient values. It takes in a one-cycle return strobe, with the status values that are valid alongside it. After a failure, the active-low reset puts the status and the control state back to their reset values, and a fresh start can follow.

Top module: `kctl_regs`

## Requirements
- R1: After reset, every register reads zero, except the control word. The control word reads 0x4: bit0 is start, bit1 is done, bit2 is idle. core_start_o is low and coef_o is zero.
- R2: A write is accepted with its address and data arriving in either order. Each write produces exactly one B response, with BRESP = 0 (OKAY). A new address or data beat is not accepted while that B response is pending.
- R3: Each accepted read produces exactly one R response, with RRESP = 0. No new read address is accepted while that R response is pending. RDATA holds steady while RVALID is high and RREADY is low.
- R4: The four coefficients sit at 0x30, 0x34, 0x38 and 0x3C. Each is read/write and honours the per-byte write strobes. Coefficient i drives coef_o[32*i +: 32].
- R5: Writing 1 to control bit0 while idle gives exactly one core_start_o pulse, lasting one cycle. The start bit then reads 0, and idle reads 0 until the kernel returns.
- R6: A start write while the kernel is running is ignored. It produces no further pulse.
- R7: A core_done_i strobe while running does two things: control reads done=1 and idle=1, and the status inputs are captured.
- R8: A read of the control word returns the done bit as it stood, then clears it. A second read shows done = 0.
- R9: The status fields are at three addresses: halted at 0x10 bit0, the error code at 0x18 bits 7:0, and the transaction ID at 0x20 bits 15:0. A core_done_i strobe while idle leaves all three unchanged.
- R10: Writes to 0x10, 0x18, 0x20 and to unmapped addresses are answered OKAY and change nothing.
- R11: Reads of unmapped addresses return zero.
- R12: Reset after a failed run clears the halted flag and the error code. A following start write launches the kernel again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_awaddr_i | input | ADDR_W | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | DATA_W | Write data |
| s_wstrb_i | input | DATA_W/8 | Write byte strobes |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | ADDR_W | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | DATA_W | Read data |
| s_rresp_o | output | 2 | Read response |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| core_start_o | output | 1 | One-cycle kernel launch pulse |
| core_done_i | input | 1 | Kernel return strobe |
| core_halted_i | input | 1 | Kernel halted on error, valid with core_done_i |
| core_err_i | input | ERR_W | Error code, valid with core_done_i |
| core_txid_i | input | TXID_W | Offending transaction ID, valid with core_done_i |
| coef_o | output | N_COEF*DATA_W | Coefficient values |

## Verification
The hardest states to reach from the ports are the ones where the control state and the core strobes are out of step: a start write arriving while the kernel runs, and a return strobe arriving while nothing runs. In both cases any captured status must survive. The bench plays the kernel itself and times its return pulses against the observed start pulse, so it can produce each of these mismatches on purpose. It also holds RREADY low across a read to freeze a response and watch that RDATA stays steady and that no new address is taken meanwhile.

// File: rtl/kctl_pkg.sv
package kctl_pkg;
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_HALT = 'h10;
  localparam int OFF_ERR  = 'h18;
  localparam int OFF_TXID = 'h20;
  localparam int OFF_COEF = 'h30;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_DONE_BIT  = 1;
  localparam int CTRL_IDLE_BIT  = 2;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {
    RUN_IDLE   = 2'd0,
    RUN_LAUNCH = 2'd1,
    RUN_BUSY   = 2'd2
  } run_state_e;
endpackage

// File: rtl/kctl_axil_wr.sv
module kctl_axil_wr #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [STRB_W-1:0] wstrb_o
);
  import kctl_pkg::*;

  logic              aw_held_q, w_held_q, bvalid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;

  assign awready_o = ~aw_held_q & ~bvalid_q;
  assign wready_o  = ~w_held_q & ~bvalid_q;
  assign we_o      = aw_held_q & w_held_q;
  assign waddr_o   = addr_q;
  assign wdata_o   = data_q;
  assign wstrb_o   = strb_q;
  assign bvalid_o  = bvalid_q;
  assign bresp_o   = RESP_OKAY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_held_q <= 1'b0;
      w_held_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      strb_q    <= '0;
    end else begin
      if (awvalid_i && awready_o) begin
        aw_held_q <= 1'b1;
        addr_q    <= awaddr_i;
      end
      if (wvalid_i && wready_o) begin
        w_held_q <= 1'b1;
        data_q   <= wdata_i;
        strb_q   <= wstrb_i;
      end
      if (we_o) begin
        aw_held_q <= 1'b0;
        w_held_q  <= 1'b0;
        bvalid_q  <= 1'b1;
      end else if (bvalid_q && bready_i) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  p_b_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o && !bready_i |=> bvalid_o);
  p_b_follows_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> bvalid_o && !awready_o && !wready_o);
  p_aw_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awvalid_i && awready_o |=> !awready_o);
endmodule

// File: rtl/kctl_axil_rd.sv
module kctl_axil_rd #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic              re_o,
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [DATA_W-1:0] mux_data_i
);
  import kctl_pkg::*;

  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign arready_o = ~rvalid_q;
  assign re_o      = arvalid_i & ~rvalid_q;
  assign raddr_o   = araddr_i;
  assign rvalid_o  = rvalid_q;
  assign rdata_o   = rdata_q;
  assign rresp_o   = RESP_OKAY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (re_o) begin
      rvalid_q <= 1'b1;
      rdata_q  <= mux_data_i;
    end else if (rvalid_q && rready_i) begin
      rvalid_q <= 1'b0;
    end
  end

  p_rdata_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && !rready_i |=> rvalid_o && $stable(rdata_o));
  p_ar_blocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arvalid_i && arready_o |=> rvalid_o && !arready_o);
endmodule

// File: rtl/kctl_run_ctrl.sv
module kctl_run_ctrl #(
  parameter int ERR_W  = 8,
  parameter int TXID_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_start_i,
  input  logic              rd_ctrl_i,
  input  logic              core_done_i,
  input  logic              core_halted_i,
  input  logic [ERR_W-1:0]  core_err_i,
  input  logic [TXID_W-1:0] core_txid_i,
  output logic              core_start_o,
  output logic              start_bit_o,
  output logic              done_bit_o,
  output logic              idle_o,
  output logic              halted_o,
  output logic [ERR_W-1:0]  err_o,
  output logic [TXID_W-1:0] txid_o
);
  import kctl_pkg::*;

  run_state_e        state_q;
  logic              done_q, halted_q;
  logic [ERR_W-1:0]  err_q;
  logic [TXID_W-1:0] txid_q;
  logic              ret_ok;

  assign ret_ok       = (state_q == RUN_BUSY) && core_done_i;
  assign core_start_o = (state_q == RUN_LAUNCH);
  assign start_bit_o  = (state_q == RUN_LAUNCH);
  assign idle_o       = (state_q == RUN_IDLE);
  assign done_bit_o   = done_q;
  assign halted_o     = halted_q;
  assign err_o        = err_q;
  assign txid_o       = txid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RUN_IDLE;
    end else begin
      unique case (state_q)
        RUN_IDLE:   if (wr_start_i) state_q <= RUN_LAUNCH;
        RUN_LAUNCH: state_q <= RUN_BUSY;
        RUN_BUSY:   if (core_done_i) state_q <= RUN_IDLE;
        default:    state_q <= RUN_IDLE;
      endcase
    end
  end

  // Return strobe wins over a coincident control read so the flag is never lost.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      halted_q <= 1'b0;
      err_q    <= '0;
      txid_q   <= '0;
    end else if (ret_ok) begin
      done_q   <= 1'b1;
      halted_q <= core_halted_i;
      err_q    <= core_err_i;
      txid_q   <= core_txid_i;
    end else if (rd_ctrl_i) begin
      done_q <= 1'b0;
    end
  end

  p_start_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |=> !core_start_o && !idle_o);
  p_busy_start_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o && wr_start_i |=> !core_start_o);
  p_return_sets_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_ok |=> done_bit_o && idle_o);
  p_status_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_ok |=> $stable(err_o) && $stable(txid_o) && $stable(halted_o));
endmodule

// File: rtl/kctl_coef_bank.sv
module kctl_coef_bank #(
  parameter int N_COEF = 4,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_COEF-1:0]        sel_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [STRB_W-1:0]        wstrb_i,
  output logic [N_COEF*DATA_W-1:0] coef_o
);
  logic [DATA_W-1:0] coef_q [N_COEF];

  for (genvar i = 0; i < N_COEF; i++) begin : g_coef
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        coef_q[i] <= '0;
      end else if (sel_i[i]) begin
        for (int b = 0; b < STRB_W; b++) begin
          if (wstrb_i[b]) coef_q[i][b*8 +: 8] <= wdata_i[b*8 +: 8];
        end
      end
    end
    assign coef_o[i*DATA_W +: DATA_W] = coef_q[i];
  end

  p_sel_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i));
  p_coef_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == '0 |=> $stable(coef_o));
endmodule

// File: rtl/kctl_regs.sv
module kctl_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int N_COEF = 4,
  parameter int ERR_W  = 8,
  parameter int TXID_W = 16,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        s_awaddr_i,
  input  logic                     s_awvalid_i,
  output logic                     s_awready_o,
  input  logic [DATA_W-1:0]        s_wdata_i,
  input  logic [STRB_W-1:0]        s_wstrb_i,
  input  logic                     s_wvalid_i,
  output logic                     s_wready_o,
  output logic [1:0]               s_bresp_o,
  output logic                     s_bvalid_o,
  input  logic                     s_bready_i,
  input  logic [ADDR_W-1:0]        s_araddr_i,
  input  logic                     s_arvalid_i,
  output logic                     s_arready_o,
  output logic [DATA_W-1:0]        s_rdata_o,
  output logic [1:0]               s_rresp_o,
  output logic                     s_rvalid_o,
  input  logic                     s_rready_i,
  output logic                     core_start_o,
  input  logic                     core_done_i,
  input  logic                     core_halted_i,
  input  logic [ERR_W-1:0]         core_err_i,
  input  logic [TXID_W-1:0]        core_txid_i,
  output logic [N_COEF*DATA_W-1:0] coef_o
);
  import kctl_pkg::*;

  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] IDX_CTRL = WIDX_W'(OFF_CTRL >> 2);
  localparam logic [WIDX_W-1:0] IDX_HALT = WIDX_W'(OFF_HALT >> 2);
  localparam logic [WIDX_W-1:0] IDX_ERR  = WIDX_W'(OFF_ERR >> 2);
  localparam logic [WIDX_W-1:0] IDX_TXID = WIDX_W'(OFF_TXID >> 2);

  logic              we, re;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] wdata, rd_mux;
  logic [STRB_W-1:0] wstrb;
  logic [WIDX_W-1:0] w_idx, r_idx;
  logic [N_COEF-1:0] coef_sel;
  logic              wr_start, rd_ctrl;
  logic              start_bit, done_bit, idle, halted;
  logic [ERR_W-1:0]  err;
  logic [TXID_W-1:0] txid;
  logic              unused_lo;

  assign w_idx     = waddr[ADDR_W-1:2];
  assign r_idx     = raddr[ADDR_W-1:2];
  assign unused_lo = ^{waddr[1:0], raddr[1:0]};

  kctl_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk_i, .rst_ni,
    .awaddr_i(s_awaddr_i), .awvalid_i(s_awvalid_i), .awready_o(s_awready_o),
    .wdata_i(s_wdata_i), .wstrb_i(s_wstrb_i), .wvalid_i(s_wvalid_i), .wready_o(s_wready_o),
    .bresp_o(s_bresp_o), .bvalid_o(s_bvalid_o), .bready_i(s_bready_i),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata), .wstrb_o(wstrb)
  );

  kctl_axil_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i, .rst_ni,
    .araddr_i(s_araddr_i), .arvalid_i(s_arvalid_i), .arready_o(s_arready_o),
    .rdata_o(s_rdata_o), .rresp_o(s_rresp_o), .rvalid_o(s_rvalid_o), .rready_i(s_rready_i),
    .re_o(re), .raddr_o(raddr), .mux_data_i(rd_mux)
  );

  assign wr_start = we && (w_idx == IDX_CTRL) && wstrb[0] && wdata[CTRL_START_BIT];
  assign rd_ctrl  = re && (r_idx == IDX_CTRL);

  for (genvar i = 0; i < N_COEF; i++) begin : g_sel
    assign coef_sel[i] = we && (w_idx == WIDX_W'((OFF_COEF >> 2) + i));
  end

  kctl_run_ctrl #(.ERR_W(ERR_W), .TXID_W(TXID_W)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_start_i(wr_start), .rd_ctrl_i(rd_ctrl),
    .core_done_i, .core_halted_i, .core_err_i, .core_txid_i,
    .core_start_o,
    .start_bit_o(start_bit), .done_bit_o(done_bit), .idle_o(idle),
    .halted_o(halted), .err_o(err), .txid_o(txid)
  );

  kctl_coef_bank #(.N_COEF(N_COEF), .DATA_W(DATA_W)) u_coef (
    .clk_i, .rst_ni,
    .sel_i(coef_sel), .wdata_i(wdata), .wstrb_i(wstrb), .coef_o
  );

  always_comb begin
    rd_mux = '0;
    if (r_idx == IDX_CTRL) begin
      rd_mux[CTRL_START_BIT] = start_bit;
      rd_mux[CTRL_DONE_BIT]  = done_bit;
      rd_mux[CTRL_IDLE_BIT]  = idle;
    end else if (r_idx == IDX_HALT) begin
      rd_mux[0] = halted;
    end else if (r_idx == IDX_ERR) begin
      rd_mux[ERR_W-1:0] = err;
    end else if (r_idx == IDX_TXID) begin
      rd_mux[TXID_W-1:0] = txid;
    end else begin
      for (int i = 0; i < N_COEF; i++) begin
        if (r_idx == WIDX_W'((OFF_COEF >> 2) + i)) rd_mux = coef_o[i*DATA_W +: DATA_W];
      end
    end
  end

  p_resp_okay_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_bvalid_o |-> s_bresp_o == 2'b00);
endmodule

// File: tb/kctl_regs_bench.sv
module kctl_regs_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [7:0]   s_awaddr_i = '0, s_araddr_i = '0;
  logic         s_awvalid_i = 0, s_wvalid_i = 0, s_bready_i = 1, s_arvalid_i = 0, s_rready_i = 1;
  logic [31:0]  s_wdata_i = '0;
  logic [3:0]   s_wstrb_i = '0;
  logic         s_awready_o, s_wready_o, s_bvalid_o, s_arready_o, s_rvalid_o;
  logic [1:0]   s_bresp_o, s_rresp_o;
  logic [31:0]  s_rdata_o;
  logic         core_start_o;
  logic         core_done_i = 0, core_halted_i = 0;
  logic [7:0]   core_err_i = '0;
  logic [15:0]  core_txid_i = '0;
  logic [127:0] coef_o;

  int n_chk = 0, n_fail = 0, start_cnt = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk_i = ~clk_i;

  kctl_regs u_kctl_regs (.*);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk_i) if (rst_ni && core_start_o) start_cnt++;

  // Monitor: compare each completed read against the scoreboard.
  initial forever begin
    @(negedge clk_i); #1;
    if (s_rvalid_o && s_rready_i) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected R", s_rdata_o, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(s_rdata_o == e, t, s_rdata_o, e);
        chk(s_rresp_o == 2'b00, "R3 rresp", {30'b0, s_rresp_o}, 32'h0);
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] st, int aw_lag, int w_lag);
    bit aw_done = 0, w_done = 0;
    int cyc = 0;
    s_awaddr_i = a; s_wdata_i = d; s_wstrb_i = st;
    while (!(aw_done && w_done)) begin
      @(negedge clk_i);
      s_awvalid_i = !aw_done && (cyc >= aw_lag);
      s_wvalid_i  = !w_done && (cyc >= w_lag);
      #1;
      if (s_awvalid_i && s_awready_o) aw_done = 1;
      if (s_wvalid_i && s_wready_o) w_done = 1;
      cyc++;
    end
    @(negedge clk_i);
    s_awvalid_i = 0; s_wvalid_i = 0;
    #1;
    while (!s_bvalid_o) begin @(negedge clk_i); #1; end
    chk(s_bresp_o == 2'b00, "R2 bresp", {30'b0, s_bresp_o}, 32'h0);
    @(negedge clk_i); #1;
    chk(!s_bvalid_o, "R2 single B", {31'b0, s_bvalid_o}, 32'h0);
  endtask

  task automatic rd_issue(logic [7:0] a, logic [31:0] e, string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk_i);
    s_araddr_i = a; s_arvalid_i = 1; #1;
    while (!s_arready_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i);
    s_arvalid_i = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string t);
    rd_issue(a, e, t);
    while (exp_q.size() != 0) begin @(negedge clk_i); #2; end
  endtask

  task automatic core_ret(bit h, logic [7:0] e, logic [15:0] tx);
    @(negedge clk_i);
    core_done_i = 1; core_halted_i = h; core_err_i = e; core_txid_i = tx;
    @(negedge clk_i);
    core_done_i = 0; core_halted_i = 0; core_err_i = '0; core_txid_i = '0;
  endtask

  task automatic idle_cycles(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    int c0;
    logic [31:0] held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    idle_cycles(1);
    chk(core_start_o == 0, "R1 start low", {31'b0, core_start_o}, 32'h0);
    chk(coef_o == '0, "R1 coef zero", coef_o[31:0], 32'h0);
    rd(8'h00, 32'h4, "R1 ctrl reset");
    rd(8'h10, 32'h0, "R1 halted reset");
    rd(8'h18, 32'h0, "R1 err reset");
    rd(8'h20, 32'h0, "R1 txid reset");

    // R4 coefficients, both channel orders
    wr(8'h30, 32'h3f80_0000, 4'hf, 0, 2);
    wr(8'h34, 32'h4000_0000, 4'hf, 3, 0);
    wr(8'h38, 32'h1234_5678, 4'hf, 0, 0);
    wr(8'h3C, 32'hAABB_CCDD, 4'h5, 1, 1);
    rd(8'h30, 32'h3f80_0000, "R4 coef0");
    rd(8'h34, 32'h4000_0000, "R4 coef1");
    rd(8'h3C, 32'h00BB_00DD, "R4 coef3 strobes");
    chk(coef_o[63:32] == 32'h4000_0000, "R4 coef_o1", coef_o[63:32], 32'h4000_0000);
    chk(coef_o[95:64] == 32'h1234_5678, "R4 coef_o2", coef_o[95:64], 32'h1234_5678);

    // R10 read-only and unmapped writes, R11 unmapped reads
    wr(8'h10, 32'h1, 4'hf, 0, 0);
    wr(8'h18, 32'hFF, 4'hf, 0, 0);
    wr(8'h20, 32'hFFFF, 4'hf, 0, 0);
    wr(8'h44, 32'hFFFF_FFFF, 4'hf, 0, 0);
    rd(8'h10, 32'h0, "R10 halted unchanged");
    rd(8'h18, 32'h0, "R10 err unchanged");
    rd(8'h20, 32'h0, "R10 txid unchanged");
    rd(8'h00, 32'h4, "R10 ctrl unchanged");
    chk(coef_o == {32'h00BB_00DD, 32'h1234_5678, 32'h4000_0000, 32'h3f80_0000},
        "R10 coef unchanged", coef_o[31:0], 32'h3f80_0000);
    rd(8'h44, 32'h0, "R11 unmapped 0x44");
    rd(8'h2C, 32'h0, "R11 unmapped 0x2C");

    // R5 launch
    c0 = start_cnt;
    wr(8'h00, 32'h1, 4'h1, 0, 0);
    idle_cycles(2);
    chk(start_cnt == c0 + 1, "R5 one pulse", start_cnt, c0 + 1);
    rd(8'h00, 32'h0, "R5 busy ctrl");
    // R6 start while busy
    wr(8'h00, 32'h1, 4'h1, 0, 0);
    idle_cycles(3);
    chk(start_cnt == c0 + 1, "R6 no pulse", start_cnt, c0 + 1);
    rd(8'h00, 32'h0, "R6 still busy");

    // R7/R8 clean return
    core_ret(0, 8'h00, 16'h0012);
    rd(8'h00, 32'h6, "R7 done idle");
    rd(8'h00, 32'h4, "R8 done cleared");
    rd(8'h20, 32'h12, "R7 txid captured");

    // R9 stray return while idle
    core_ret(1, 8'h05, 16'h0777);
    rd(8'h10, 32'h0, "R9 stray halted");
    rd(8'h18, 32'h0, "R9 stray err");
    rd(8'h00, 32'h4, "R9 stray ctrl");

    // failed run
    wr(8'h00, 32'h1, 4'h1, 0, 0);
    idle_cycles(2);
    core_ret(1, 8'h2A, 16'hBEEF);
    rd(8'h10, 32'h1, "R9 halted");
    rd(8'h18, 32'h2A, "R9 err");
    rd(8'h20, 32'hBEEF, "R9 txid");

    // R3 back-pressure
    @(negedge clk_i); s_rready_i = 0;
    rd_issue(8'h38, 32'h1234_5678, "R3 stalled read");
    #1;
    while (!s_rvalid_o) begin @(negedge clk_i); #1; end
    held = s_rdata_o;
    idle_cycles(3); #1;
    chk(s_rvalid_o && s_rdata_o == held, "R3 rdata stable", s_rdata_o, held);
    chk(!s_arready_o, "R3 ar blocked", {31'b0, s_arready_o}, 32'h0);
    @(negedge clk_i); s_rready_i = 1;
    while (exp_q.size() != 0) begin @(negedge clk_i); #2; end

    // R12 reset after failure
    @(negedge clk_i); rst_ni = 0;
    idle_cycles(2);
    rst_ni = 1;
    idle_cycles(1);
    rd(8'h10, 32'h0, "R12 halted cleared");
    rd(8'h18, 32'h0, "R12 err cleared");
    rd(8'h00, 32'h4, "R12 ctrl idle");
    rd(8'h30, 32'h0, "R1 coef cleared by reset");
    c0 = start_cnt;
    wr(8'h00, 32'h1, 4'h1, 0, 0);
    idle_cycles(2);
    chk(start_cnt == c0 + 1, "R12 relaunch", start_cnt, c0 + 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule